// File: doc/BRIEF.md
# Prefetch and Post-Write Engine Controller

This block steers a byte FIFO that sits between a host and an external memory chip-select. In read-prefetch mode it asks the memory sequencer for bytes and fills the FIFO ahead of the host. In write-posting mode the host deposits bytes in the FIFO and the block asks the sequencer to drain them to memory. The FIFO storage itself lives elsewhere; this controller only tracks how full it is, counts the bytes still owed to memory, and decides when to request memory accesses and when to signal the host.

A transfer starts from a one-cycle start command carrying a byte count. The start can be released at once, or it can be held until a chosen external wait input drops from wait to non-wait. Each wait input passes through a two-flop synchronizer before its falling edge is detected. Host synchronization is set by a programmable byte threshold. In interrupt mode the block pulses an interrupt when the FIFO level crosses the threshold. In DMA mode it holds a request until the host has moved a threshold's worth of bytes, then drops the request and looks at the level again.

Top module: `pfpw_engine_ctrl`

## Requirements
- R1: After reset, mem_req, irq, dma_req, done and busy are all 0.
- R2: While cfg_enable is 0, a start command is ignored and busy and mem_req stay 0. Clearing cfg_enable during a transfer drops busy and mem_req on the next cycle.
- R3: With cfg_sync_start = 0, a start taken while idle and enabled sets busy and mem_req in the cycle after the start edge.
- R4: With cfg_sync_start = 1, the engine is busy but makes no memory request until wait_in[cfg_wait_sel] falls from 1 (wait) to 0. mem_req rises three edges after the input falls. Edges on other wait inputs, and edges seen before the start, have no effect.
- R5: In prefetch mode (cfg_write_mode = 0), mem_req is held low while 64 bytes are filled. In post-write mode (cfg_write_mode = 1), mem_req is held low while 0 bytes are filled. A mem_ack adds one filled byte in prefetch mode and removes one in post-write mode. A host_xfer does the reverse.
- R6: Each mem_ack taken while mem_req is high uses up one byte of the transfer count. Once the count is used up, mem_req drops. One cycle later busy falls and done rises. done stays high until the next accepted start.
- R7: In interrupt mode (cfg_dma_mode = 0), irq is a one-cycle pulse that fires when the level goes from below the effective threshold to at or above it while running. The level is the filled bytes in prefetch mode and the free bytes (64 minus filled) in post-write mode.
- R8: In DMA mode (cfg_dma_mode = 1), irq stays 0. dma_req rises one cycle after the threshold condition holds while running. It stays high until the effective-threshold number of host_xfer cycles have occurred, drops in the cycle after the last one, and is then raised again one cycle later only if the condition still holds.
- R9: The effective threshold is the 7-bit cfg_threshold, with 0 treated as 1 and values above 64 treated as 64.
- R10: mem_cs and mem_write give the chip-select (0 to 7) and direction captured at the accepted start, and they hold for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Engine enable |
| cfg_write_mode | input | 1 | 0 read prefetch, 1 write posting |
| cfg_cs_sel | input | 3 | Target chip-select |
| cfg_sync_start | input | 1 | Hold the start until a wait-pin release |
| cfg_wait_sel | input | 2 | Wait input used for synchronized start |
| cfg_dma_mode | input | 1 | 0 interrupt, 1 DMA request |
| cfg_threshold | input | 7 | Host threshold in bytes |
| start | input | 1 | Start command pulse |
| xfer_bytes | input | 16 | Byte count of the transfer, taken at start |
| wait_in | input | 4 | External wait inputs, high means wait |
| mem_ack | input | 1 | One byte moved by the sequencer |
| host_xfer | input | 1 | One byte moved by the host |
| mem_req | output | 1 | Access request to the sequencer |
| mem_cs | output | 3 | Chip-select of the request |
| mem_write | output | 1 | Direction of the request |
| irq | output | 1 | Threshold interrupt pulse |
| dma_req | output | 1 | DMA request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer count used up |

## Verification
The hardest situation to reach is the synchronized start. The selected wait input must already read as waiting through the synchronizer before the start, and then it must be released after the engine is armed, while releases on the other inputs must stay harmless. The bench holds every wait input high for several cycles, arms the engine, releases a non-selected input, and then releases the selected one, counting the edges until the request appears. It also repeats the release before the start to show that a stale edge does not fire. The DMA re-evaluation edge is reached by sweeping thresholds in post-write mode and pushing exactly one threshold's worth of bytes.

// File: rtl/pfpw_pkg.sv
package pfpw_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ARMED = 2'd1,
    ENG_RUN   = 2'd2
  } eng_state_e;

  typedef enum logic {
    HS_WAIT = 1'b0,
    HS_REQ  = 1'b1
  } hs_state_e;

endpackage

// File: rtl/pfpw_wait_edge.sv
module pfpw_wait_edge #(
  parameter int N_WAIT      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_WAIT-1:0] wait_in,
  output logic [N_WAIT-1:0] release_pulse
);

  for (genvar g = 0; g < N_WAIT; g++) begin : g_pin
    logic [SYNC_STAGES-1:0] sync_q;
    logic [SYNC_STAGES-1:0] sync_d;
    logic                   last_q;

    always_comb begin
      sync_d = {sync_q[SYNC_STAGES-2:0], wait_in[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        last_q <= 1'b0;
      end else begin
        sync_q <= sync_d;
        last_q <= sync_q[SYNC_STAGES-1];
      end
    end

    // wait (1) to non-wait (0) transition on the synchronized level
    assign release_pulse[g] = last_q & ~sync_q[SYNC_STAGES-1];
  end

endmodule

// File: rtl/pfpw_level_track.sv
module pfpw_level_track #(
  parameter int FIFO_BYTES = 64,
  parameter int XFER_W     = 16,
  parameter int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [XFER_W-1:0] load_bytes,
  input  logic              write_mode,
  input  logic              mem_moved,
  input  logic              host_moved,
  output logic [LVL_W-1:0]  fill,
  output logic [XFER_W-1:0] remaining
);

  localparam logic [LVL_W-1:0] FULL = LVL_W'(FIFO_BYTES);

  logic [LVL_W-1:0]  fill_q, fill_d;
  logic [XFER_W-1:0] rem_q, rem_d;
  logic              push, pop, push_ok, pop_ok;

  always_comb begin
    push    = write_mode ? host_moved : mem_moved;
    pop     = write_mode ? mem_moved  : host_moved;
    pop_ok  = pop & (fill_q != '0);
    push_ok = push & ((fill_q != FULL) | pop_ok);
    if (clr) begin
      fill_d = '0;
      rem_d  = '0;
    end else if (load) begin
      fill_d = '0;
      rem_d  = load_bytes;
    end else begin
      fill_d = fill_q;
      if (push_ok && !pop_ok) fill_d = fill_q + 1'b1;
      if (pop_ok && !push_ok) fill_d = fill_q - 1'b1;
      rem_d = (mem_moved && rem_q != '0) ? rem_q - 1'b1 : rem_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      rem_q  <= '0;
    end else begin
      fill_q <= fill_d;
      rem_q  <= rem_d;
    end
  end

  assign fill      = fill_q;
  assign remaining = rem_q;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL); // R5

endmodule

// File: rtl/pfpw_host_sig.sv
module pfpw_host_sig
  import pfpw_pkg::*;
#(
  parameter int FIFO_BYTES = 64,
  parameter int THR_W      = 7,
  parameter int LVL_W      = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             dma_mode,
  input  logic             write_mode,
  input  logic [THR_W-1:0] thr_field,
  input  logic [LVL_W-1:0] fill,
  input  logic             host_moved,
  output logic             irq,
  output logic             dma_req
);

  localparam logic [LVL_W-1:0] FULL = LVL_W'(FIFO_BYTES);

  logic [LVL_W-1:0] eff_thr, level, quota_q, quota_d;
  logic             trip, trip_q;
  hs_state_e        hs_q, hs_d;

  always_comb begin
    if (thr_field == '0)                       eff_thr = LVL_W'(1);
    else if (thr_field > THR_W'(FIFO_BYTES))   eff_thr = FULL;
    else                                       eff_thr = LVL_W'(thr_field);
    level = write_mode ? (FULL - fill) : fill;
    trip  = run & (level >= eff_thr);
  end

  always_comb begin
    hs_d    = hs_q;
    quota_d = quota_q;
    case (hs_q)
      HS_WAIT: begin
        if (dma_mode && trip) begin
          hs_d    = HS_REQ;
          quota_d = eff_thr;
        end
      end
      HS_REQ: begin
        if (!run || !dma_mode) begin
          hs_d = HS_WAIT;
        end else if (host_moved) begin
          if (quota_q <= LVL_W'(1)) hs_d = HS_WAIT;
          else                      quota_d = quota_q - 1'b1;
        end
      end
      default: hs_d = HS_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= HS_WAIT;
      quota_q <= '0;
      trip_q  <= 1'b0;
    end else begin
      hs_q    <= hs_d;
      quota_q <= quota_d;
      trip_q  <= trip;
    end
  end

  assign irq     = ~dma_mode & trip & ~trip_q;
  assign dma_req = (hs_q == HS_REQ);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7
  AST_DMA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && run && dma_mode && host_moved && quota_q == LVL_W'(1)) |=> !dma_req); // R8

endmodule

// File: rtl/pfpw_engine_ctrl.sv
module pfpw_engine_ctrl
  import pfpw_pkg::*;
#(
  parameter int FIFO_BYTES = 64,
  parameter int THR_W      = 7,
  parameter int XFER_W     = 16,
  parameter int N_WAIT     = 4,
  parameter int N_CS       = 8,
  localparam int LVL_W     = $clog2(FIFO_BYTES + 1),
  localparam int CS_W      = $clog2(N_CS),
  localparam int WSEL_W    = $clog2(N_WAIT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_write_mode,
  input  logic [CS_W-1:0]   cfg_cs_sel,
  input  logic              cfg_sync_start,
  input  logic [WSEL_W-1:0] cfg_wait_sel,
  input  logic              cfg_dma_mode,
  input  logic [THR_W-1:0]  cfg_threshold,
  input  logic              start,
  input  logic [XFER_W-1:0] xfer_bytes,
  input  logic [N_WAIT-1:0] wait_in,
  input  logic              mem_ack,
  input  logic              host_xfer,
  output logic              mem_req,
  output logic [CS_W-1:0]   mem_cs,
  output logic              mem_write,
  output logic              irq,
  output logic              dma_req,
  output logic              busy,
  output logic              done
);

  localparam logic [LVL_W-1:0] FULL = LVL_W'(FIFO_BYTES);

  eng_state_e        st_q, st_d;
  logic [CS_W-1:0]   cs_q, cs_d;
  logic              dir_q, dir_d;
  logic [WSEL_W-1:0] wsel_q, wsel_d;
  logic              done_q, done_d;
  logic              take_start, finish;
  logic [N_WAIT-1:0] release_pulse;
  logic [LVL_W-1:0]  fill;
  logic [XFER_W-1:0] remaining;
  logic              running, mem_moved, host_moved;

  pfpw_wait_edge #(.N_WAIT(N_WAIT), .SYNC_STAGES(2)) u_wait (
    .clk           (clk),
    .rst_n         (rst_n),
    .wait_in       (wait_in),
    .release_pulse (release_pulse)
  );

  always_comb begin
    take_start = cfg_enable & start & (st_q == ENG_IDLE);
    finish     = (st_q == ENG_RUN) & (remaining == '0);
    st_d       = st_q;
    cs_d       = cs_q;
    dir_d      = dir_q;
    wsel_d     = wsel_q;
    done_d     = done_q;
    if (!cfg_enable) begin
      st_d   = ENG_IDLE;
      done_d = 1'b0;
    end else begin
      case (st_q)
        ENG_IDLE: begin
          if (take_start) begin
            st_d   = cfg_sync_start ? ENG_ARMED : ENG_RUN;
            cs_d   = cfg_cs_sel;
            dir_d  = cfg_write_mode;
            wsel_d = cfg_wait_sel;
            done_d = 1'b0;
          end
        end
        ENG_ARMED: begin
          if (release_pulse[wsel_q]) st_d = ENG_RUN;
        end
        ENG_RUN: begin
          if (finish) begin
            st_d   = ENG_IDLE;
            done_d = 1'b1;
          end
        end
        default: st_d = ENG_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      cs_q   <= '0;
      dir_q  <= 1'b0;
      wsel_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cs_q   <= cs_d;
      dir_q  <= dir_d;
      wsel_q <= wsel_d;
      done_q <= done_d;
    end
  end

  assign running    = (st_q == ENG_RUN);
  assign mem_req    = running & (remaining != '0) &
                      (dir_q ? (fill != '0) : (fill != FULL));
  assign mem_moved  = mem_ack & mem_req;
  assign host_moved = host_xfer & cfg_enable;

  pfpw_level_track #(.FIFO_BYTES(FIFO_BYTES), .XFER_W(XFER_W), .LVL_W(LVL_W)) u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (~cfg_enable),
    .load       (take_start),
    .load_bytes (xfer_bytes),
    .write_mode (dir_q),
    .mem_moved  (mem_moved),
    .host_moved (host_moved),
    .fill       (fill),
    .remaining  (remaining)
  );

  pfpw_host_sig #(.FIFO_BYTES(FIFO_BYTES), .THR_W(THR_W), .LVL_W(LVL_W)) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (running),
    .dma_mode   (cfg_dma_mode),
    .write_mode (dir_q),
    .thr_field  (cfg_threshold),
    .fill       (fill),
    .host_moved (host_moved),
    .irq        (irq),
    .dma_req    (dma_req)
  );

  assign mem_cs    = cs_q;
  assign mem_write = dir_q;
  assign busy      = (st_q != ENG_IDLE);
  assign done      = done_q;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!busy && !mem_req)); // R2
  AST_IMMEDIATE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (take_start && !cfg_sync_start) |=> busy && running); // R3
  AST_LAST_ACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_moved && remaining == XFER_W'(1) && cfg_enable) |=> !mem_req); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && !mem_req)); // R6
  AST_TARGET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mem_cs) && $stable(mem_write))); // R10

endmodule

// File: tb/pfpw_engine_ctrl_tb.sv
module pfpw_engine_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable, cfg_write_mode, cfg_sync_start, cfg_dma_mode;
  logic [2:0]  cfg_cs_sel;
  logic [1:0]  cfg_wait_sel;
  logic [6:0]  cfg_threshold;
  logic        start, mem_ack, host_xfer;
  logic [15:0] xfer_bytes;
  logic [3:0]  wait_in;
  logic        mem_req, mem_write, irq, dma_req, busy, done;
  logic [2:0]  mem_cs;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfpw_engine_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_write_mode(cfg_write_mode),
    .cfg_cs_sel(cfg_cs_sel), .cfg_sync_start(cfg_sync_start), .cfg_wait_sel(cfg_wait_sel),
    .cfg_dma_mode(cfg_dma_mode), .cfg_threshold(cfg_threshold), .start(start),
    .xfer_bytes(xfer_bytes), .wait_in(wait_in), .mem_ack(mem_ack), .host_xfer(host_xfer),
    .mem_req(mem_req), .mem_cs(mem_cs), .mem_write(mem_write), .irq(irq),
    .dma_req(dma_req), .busy(busy), .done(done)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic go(input int nbytes);
    xfer_bytes = 16'(nbytes);
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic reenable();
    cfg_enable = 1'b0;
    tick();
    cfg_enable = 1'b1;
  endtask

  task automatic ack_one();
    mem_ack = 1'b1;
    tick();
    mem_ack = 1'b0;
  endtask

  task automatic host_one();
    host_xfer = 1'b1;
    tick();
    host_xfer = 1'b0;
  endtask

  function automatic int eff_thr(input int t);
    if (t == 0) return 1;
    if (t > 64) return 64;
    return t;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_enable = 0; cfg_write_mode = 0; cfg_sync_start = 0; cfg_dma_mode = 0;
    cfg_cs_sel = 0; cfg_wait_sel = 0; cfg_threshold = 7'd16;
    start = 0; mem_ack = 0; host_xfer = 0; xfer_bytes = 0; wait_in = 4'hF;
    repeat (3) tick();
    // R1 reset state
    chk("R1 mem_req", mem_req, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 done", done, 0);
    chk("R1 busy", busy, 0);
    rst_n = 1'b1;
    tick();

    // R2 start ignored while disabled
    go(4);
    chk("R2 busy disabled", busy, 0);
    chk("R2 mem_req disabled", mem_req, 0);

    // R3 / R10 / R6 immediate start, every chip-select
    cfg_enable = 1'b1;
    for (int cs = 0; cs < 8; cs++) begin
      cfg_cs_sel = 3'(cs);
      cfg_write_mode = 1'b0;
      go(3);
      cfg_cs_sel = 3'(7 - cs);
      chk("R3 busy", busy, 1);
      chk("R3 mem_req", mem_req, 1);
      chk("R10 mem_cs", mem_cs, cs);
      chk("R10 mem_write", mem_write, 0);
      for (int k = 0; k < 3; k++) ack_one();
      chk("R6 mem_req after count", mem_req, 0);
      chk("R6 busy still", busy, 1);
      chk("R10 mem_cs held", mem_cs, cs);
      tick();
      chk("R6 done", done, 1);
      chk("R6 busy low", busy, 0);
      tick();
      chk("R6 done sticky", done, 1);
    end
    go(2);
    chk("R6 done cleared by start", done, 0);
    // R2 disable mid-transfer
    cfg_enable = 1'b0;
    tick();
    chk("R2 busy after disable", busy, 0);
    chk("R2 mem_req after disable", mem_req, 0);
    cfg_enable = 1'b1;
    tick();

    // R7 / R9 prefetch interrupt threshold sweep
    cfg_write_mode = 1'b0;
    cfg_dma_mode = 1'b0;
    for (int t = 0; t <= 72; t++) begin
      int pulses, at;
      cfg_threshold = 7'(t);
      reenable();
      go(64);
      pulses = 0;
      at = -1;
      for (int k = 1; k <= 64; k++) begin
        ack_one();
        if (irq) begin
          pulses++;
          at = k;
        end
      end
      tick();
      if (irq) pulses++;
      chk("R9 R7 irq position", at, eff_thr(t));
      chk("R7 irq pulse count", pulses, 1);
    end

    // R7 post-write: free space at start already over threshold
    cfg_write_mode = 1'b1;
    cfg_threshold = 7'd16;
    reenable();
    go(8);
    chk("R7 post-write irq at start", irq, 1);
    tick();
    chk("R7 post-write irq one cycle", irq, 0);

    // R5 post-write: no request while empty, request once data present
    chk("R5 post-write empty", mem_req, 0);
    host_one();
    chk("R5 post-write data", mem_req, 1);
    chk("R10 write dir", mem_write, 1);
    ack_one();
    chk("R5 post-write drained", mem_req, 0);

    // R5 prefetch: no request while full
    cfg_write_mode = 1'b0;
    reenable();
    go(100);
    for (int k = 0; k < 64; k++) ack_one();
    chk("R5 prefetch full", mem_req, 0);
    ack_one();
    chk("R5 ack ignored when full", mem_req, 0);
    host_one();
    chk("R5 prefetch space", mem_req, 1);

    // R8 DMA sweep in post-write mode
    cfg_write_mode = 1'b1;
    cfg_dma_mode = 1'b1;
    for (int t = 1; t <= 64; t++) begin
      int bad_hold;
      cfg_threshold = 7'(t);
      reenable();
      go(64);
      chk("R8 no irq in dma", irq, 0);
      tick();
      chk("R8 dma_req raised", dma_req, 1);
      bad_hold = 0;
      for (int i = 1; i <= t; i++) begin
        host_one();
        if (i < t && !dma_req) bad_hold++;
        if (irq) bad_hold++;
      end
      chk("R8 dma_req held", bad_hold, 0);
      chk("R8 dma_req drop", dma_req, 0);
      tick();
      chk("R8 dma_req re-eval", dma_req, (64 - t >= t) ? 1 : 0);
    end
    cfg_dma_mode = 1'b0;

    // R4 synchronized start
    cfg_write_mode = 1'b0;
    cfg_sync_start = 1'b1;
    for (int p = 0; p < 4; p++) begin
      int other;
      other = (p + 1) % 4;
      cfg_wait_sel = 2'(p);
      wait_in = 4'hF;
      reenable();
      repeat (4) tick();
      go(2);
      chk("R4 armed busy", busy, 1);
      chk("R4 armed no req", mem_req, 0);
      wait_in[other] = 1'b0;
      repeat (5) tick();
      chk("R4 other pin ignored", mem_req, 0);
      wait_in[p] = 1'b0;
      tick();
      tick();
      chk("R4 not yet after two edges", mem_req, 0);
      tick();
      chk("R4 req after three edges", mem_req, 1);
    end
    // R4 release before start has no effect
    cfg_wait_sel = 2'd2;
    wait_in = 4'hF;
    reenable();
    repeat (4) tick();
    wait_in[2] = 1'b0;
    repeat (5) tick();
    go(2);
    repeat (5) tick();
    chk("R4 stale edge ignored", mem_req, 0);
    wait_in[2] = 1'b1;
    repeat (4) tick();
    wait_in[2] = 1'b0;
    repeat (3) tick();
    chk("R4 fresh edge starts", mem_req, 1);
    cfg_sync_start = 1'b0;

    finish_run();
  end

endmodule